// File: doc/BRIEF.md
# Sticky Secure-Reset Error Status Register

This block holds an 8-bit error status word that records security-related reset events. Its status bits are kept through warm resets, and only a power-on reset clears them. Two bits carry meaning. The wake-error flag is decided during each warm reset by the acknowledge message the processor returns. A "done, secrets may remain" acknowledge sets the flag. A plain "done" acknowledge clears it. Software can also clear the flag by writing a one to its position. When a reset sets the flag, a memory-block output closes the memory path. The path stays closed until an explicit enable command arrives.

The secure-reset flag is set by a one-cycle event pulse. Software can only read it, and only a power cycle clears it. While it is set, a launch-inhibit output makes every attempt to enter a measured environment fail. Ordinary register reads keep working. All other bit positions are reserved.

Top module: `sec_rst_status`

## Requirements
- R1: After power-on reset (`por_n` low), `rd_data` reads 0x00 and both `mem_block` and `launch_inhibit` are 0.
- R2: A warm reset (`warm_rst_n` low) with no acknowledge strobe leaves `rd_data` and `mem_block` unchanged.
- R3: `ack_secret` seen at a clock edge while `warm_rst_n` is low sets the wake-error flag (`rd_data` bit 6). It also sets `mem_block`. Both are visible after that edge.
- R4: `ack_clean` seen at a clock edge while `warm_rst_n` is low, without `ack_secret`, clears bit 6 and `mem_block` after that edge.
- R5: Acknowledge strobes that arrive while `warm_rst_n` is high have no effect on bit 6 or `mem_block`.
- R6: A bus write (`wr_en`) with `wr_data` bit 6 at 1 clears bit 6 after the edge. A write with bit 6 at 0 leaves it unchanged. Writes never change `mem_block`.
- R7: When a reset-time `ack_secret` and a write-1 to bit 6 occur in the same cycle, the set wins and bit 6 reads 1.
- R8: A one-cycle `mem_enable` pulse drops `mem_block` after the next edge and leaves bit 6 unchanged. A later reset with `ack_secret` raises `mem_block` again.
- R9: A `srst_event` pulse sets the secure-reset flag (`rd_data` bit 0) at the next edge. `launch_inhibit` equals that flag.
- R10: Bus writes and warm resets never change bit 0. Only `por_n` clears it.
- R11: Bits 7 and 5:1 always read 0, whatever value is written.
- R12: If both acknowledge strobes arrive in the same reset cycle, `ack_secret` takes effect and bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| warm_rst_n | input | 1 | Warm reset window, active low; sampled on the clock |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Current status word |
| ack_secret | input | 1 | Reset-done acknowledge, secrets may be present |
| ack_clean | input | 1 | Plain reset-done acknowledge |
| mem_enable | input | 1 | Command that reopens the memory path |
| srst_event | input | 1 | Secure-environment reset event pulse |
| mem_block | output | 1 | Memory accesses blocked when 1 |
| launch_inhibit | output | 1 | Measured-environment launch refused when 1 |

## Verification
The hardest case to reach is a collision inside the reset window. A software write-1-to-clear has to land in the same cycle as a reset-time "secrets present" acknowledge, or both acknowledges have to arrive together. The bench gets there by holding `warm_rst_n` low and raising the strobes and the write together on one cycle. It also checks stickiness by setting both flags, running warm resets and all-ones writes, and only then pulsing power-on reset.

// File: rtl/sec_status_pkg.sv
package sec_status_pkg;
  localparam int STAT_W   = 8;
  localparam int WAKE_BIT = 6;
  localparam int SRST_BIT = 0;

  // Assemble the visible status word; reserved positions stay zero.
  function automatic logic [STAT_W-1:0] pack_status(input logic wake, input logic srst);
    logic [STAT_W-1:0] w;
    w = '0;
    w[WAKE_BIT] = wake;
    w[SRST_BIT] = srst;
    return w;
  endfunction
endpackage

// File: rtl/wake_err_ctl.sv
module wake_err_ctl (
  input  logic clk,
  input  logic por_n,
  input  logic in_reset,
  input  logic ack_secret,
  input  logic ack_clean,
  input  logic sw_clear,
  input  logic mem_enable,
  output logic wake_q,
  output logic mem_block_q
);
  // Named events for the checks below
  logic hw_set, hw_clr;
  assign hw_set = in_reset & ack_secret;
  assign hw_clr = in_reset & ack_clean & ~ack_secret;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wake_q <= 1'b0;
    end else if (hw_set) begin
      wake_q <= 1'b1;
    end else if (hw_clr || sw_clear) begin
      wake_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mem_block_q <= 1'b0;
    end else if (hw_set) begin
      mem_block_q <= 1'b1;
    end else if (hw_clr || mem_enable) begin
      mem_block_q <= 1'b0;
    end
  end

  a_r3_secret_sets: assert property (@(posedge clk) disable iff (!por_n)
    (in_reset && ack_secret) |=> (wake_q && mem_block_q));
  a_r4_clean_clears: assert property (@(posedge clk) disable iff (!por_n)
    (in_reset && ack_clean && !ack_secret) |=> (!wake_q && !mem_block_q));
  a_r5_acks_ignored_outside: assert property (@(posedge clk) disable iff (!por_n)
    (!in_reset && !sw_clear) |=> $stable(wake_q));
  a_r6_w1c: assert property (@(posedge clk) disable iff (!por_n)
    (sw_clear && !(in_reset && ack_secret)) |=> !wake_q);
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!por_n)
    (sw_clear && in_reset && ack_secret) |=> wake_q);
  a_r8_enable_unblocks: assert property (@(posedge clk) disable iff (!por_n)
    (mem_enable && !(in_reset && ack_secret)) |=> !mem_block_q);
endmodule

// File: rtl/srst_flag.sv
module srst_flag (
  input  logic clk,
  input  logic por_n,
  input  logic evt,
  output logic flag_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b0;
    end else if (evt) begin
      flag_q <= 1'b1;
    end
  end

  a_r9_event_sets: assert property (@(posedge clk) disable iff (!por_n)
    evt |=> flag_q);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!por_n)
    flag_q |=> flag_q);
endmodule

// File: rtl/sec_rst_status.sv
module sec_rst_status
  import sec_status_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data,
  input  logic              ack_secret,
  input  logic              ack_clean,
  input  logic              mem_enable,
  input  logic              srst_event,
  output logic              mem_block,
  output logic              launch_inhibit
);
  logic in_reset, sw_clear, wake, srst;

  assign in_reset = ~warm_rst_n;
  assign sw_clear = wr_en & wr_data[WAKE_BIT];

  wake_err_ctl u_wake (
    .clk(clk), .por_n(por_n), .in_reset(in_reset),
    .ack_secret(ack_secret), .ack_clean(ack_clean),
    .sw_clear(sw_clear), .mem_enable(mem_enable),
    .wake_q(wake), .mem_block_q(mem_block)
  );

  srst_flag u_srst (
    .clk(clk), .por_n(por_n), .evt(srst_event), .flag_q(srst)
  );

  assign rd_data        = pack_status(wake, srst);
  assign launch_inhibit = srst;

  a_r2_warm_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (in_reset && !ack_secret && !ack_clean && !wr_en && !mem_enable && !srst_event)
      |=> ($stable(rd_data) && $stable(mem_block)));
  a_r10_write_no_srst: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !srst_event) |=> (rd_data[SRST_BIT] == $past(rd_data[SRST_BIT])));
endmodule

// File: tb/sec_rst_status_bench.sv
module sec_rst_status_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, warm_rst_n = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic ack_secret = 1'b0, ack_clean = 1'b0, mem_enable = 1'b0, srst_event = 1'b0;
  logic mem_block, launch_inhibit;

  int n_chk = 0, n_bad = 0;
  // bench-side expectations
  logic e_wake = 1'b0, e_srst = 1'b0, e_blk = 1'b0;

  always #5 clk = ~clk;

  sec_rst_status u_sec_rst_status (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ack_secret(ack_secret), .ack_clean(ack_clean),
    .mem_enable(mem_enable), .srst_event(srst_event),
    .mem_block(mem_block), .launch_inhibit(launch_inhibit)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_word();
    return {1'b0, e_wake, 5'b00000, e_srst};
  endfunction

  task automatic check_all(input string req);
    chk({req, " rd_data"}, rd_data, expect_word());
    chk({req, " mem_block"}, {7'd0, mem_block}, {7'd0, e_blk});
    chk({req, " launch_inhibit"}, {7'd0, launch_inhibit}, {7'd0, e_srst});
  endtask

  task automatic do_por();
    por_n = 1'b0;
    tick();
    por_n = 1'b1;
    tick();
    e_wake = 0; e_srst = 0; e_blk = 0;
  endtask

  // warm reset window with optional acknowledge on its middle cycle
  task automatic warm_cycle(input logic sec, input logic cln);
    warm_rst_n = 1'b0;
    tick();
    ack_secret = sec; ack_clean = cln;
    tick();
    ack_secret = 0; ack_clean = 0;
    warm_rst_n = 1'b1;
    tick();
    if (sec) begin e_wake = 1; e_blk = 1; end
    else if (cln) begin e_wake = 0; e_blk = 0; end
  endtask

  task automatic bus_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = 8'h00;
    if (d[6]) e_wake = 0;
  endtask

  task automatic t_por();
    do_por();
    check_all("R1");
  endtask

  task automatic t_secret();
    warm_cycle(1, 0);
    check_all("R3");
    warm_cycle(0, 0);
    check_all("R2");
  endtask

  task automatic t_outside();
    ack_clean = 1; tick(); ack_clean = 0; tick();
    check_all("R5 clean outside");
    bus_write(8'h40);
    ack_secret = 1; tick(); ack_secret = 0; tick();
    check_all("R5 secret outside");
  endtask

  task automatic t_w1c();
    warm_cycle(1, 0);
    bus_write(8'hBF);
    check_all("R6 write0");
    bus_write(8'h40);
    check_all("R6 write1");
  endtask

  task automatic t_clean();
    warm_cycle(1, 0);
    warm_cycle(0, 1);
    check_all("R4");
  endtask

  task automatic t_priority();
    warm_rst_n = 0; tick();
    ack_secret = 1; wr_en = 1; wr_data = 8'h40;
    tick();
    ack_secret = 0; wr_en = 0; wr_data = 0; warm_rst_n = 1;
    tick();
    e_wake = 1; e_blk = 1;
    check_all("R7");
  endtask

  task automatic t_enable();
    warm_cycle(1, 0);
    mem_enable = 1; tick(); mem_enable = 0;
    e_blk = 0;
    check_all("R8 unblock");
    warm_cycle(1, 0);
    check_all("R8 reblock");
  endtask

  task automatic t_both();
    warm_cycle(0, 1);
    warm_cycle(1, 1);
    check_all("R12");
  endtask

  task automatic t_srst();
    bus_write(8'h01);
    check_all("R10 write1 no set");
    srst_event = 1; tick(); srst_event = 0;
    e_srst = 1;
    check_all("R9");
    bus_write(8'hFF);
    check_all("R10 write ones");
    bus_write(8'h00);
    warm_cycle(0, 1);
    check_all("R10 warm");
  endtask

  task automatic t_reserved();
    warm_cycle(1, 0);
    bus_write(8'hBE);
    check_all("R11");
  endtask

  task automatic t_power();
    do_por();
    check_all("R10 por clears");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_por();
    t_secret();
    t_outside();
    t_w1c();
    t_clean();
    t_priority();
    t_enable();
    t_both();
    t_srst();
    t_reserved();
    t_power();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule